// File: doc/BRIEF.md
# Interval Timer Channel with Toggle Output

This block is a single down-counting timer channel. Software loads a period value and pulses a start strobe. From then on the counter counts down once per count-clock enable. Each time it passes through zero it reloads from the period value, raises a one-cycle interrupt pulse and inverts a square-wave output. A mode bit chooses whether the first load after a start also fires the interrupt and the toggle. A stop strobe freezes the counter value and the output level where they stand.

The output level has two owners. While the output-enable bit is clear, software owns the level and writes it directly. While the bit is set, the timer toggles the level, and software can write it only while the channel is stopped. The counter value, the period, the run flag and the mode bit are visible on output ports at all times.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the count reads FFFFh, the period reads 0000h, and the wave output, run flag, interrupt, mode bit and output-enable bit all read 0.
- R2: A start strobe sets the run flag on the next clock edge. The first count-clock enable after that copies the period value into the counter.
- R3: When the mode bit is 1, the start load also raises the interrupt and toggles the wave (if output is enabled). When the mode bit is 0, the start load does neither.
- R4: While running, each count-clock enable decrements the counter. An enable that finds the counter at 0000h reloads the period instead, raises the interrupt for exactly one cycle and toggles the wave (if output is enabled). Without an enable the counter holds.
- R5: The period may be rewritten while running. The counter finishes its current countdown and picks up the new value at the next reload.
- R6: A mode-bit write is ignored while the channel runs and accepted while it is stopped.
- R7: A stop strobe clears the run flag. Afterwards the counter, the wave level and the interrupt stay unchanged under further count-clock enables.
- R8: While output-enable is 0, the wave follows each level write, including while running, and the timer never toggles it.
- R9: While output-enable is 1, a level write is ignored if the channel runs and accepted if it is stopped.
- R10: Start and stop in the same cycle leave the channel stopped. A start while running restarts with a fresh period load on the next count-clock enable.
- R11: A period of 0000h gives an interrupt and a toggle on every count-clock enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable, one cycle per count tick |
| start_trig | input | 1 | One-cycle start strobe |
| stop_trig | input | 1 | One-cycle stop strobe |
| period_we | input | 1 | Period write strobe |
| period_din | input | 16 | Period write data |
| mode_we | input | 1 | Mode-bit write strobe |
| mode_din | input | 1 | Mode bit: 1 = fire at start load |
| oe_we | input | 1 | Output-enable write strobe |
| oe_din | input | 1 | Output-enable write data |
| lvl_we | input | 1 | Level write strobe |
| lvl_din | input | 1 | Level write data |
| count_val | output | 16 | Current counter value |
| period_val | output | 16 | Current period value |
| running | output | 1 | Channel-enable status flag |
| mode_val | output | 1 | Current mode bit |
| oe_val | output | 1 | Current output-enable bit |
| wave_out | output | 1 | Square-wave output level |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Some properties are checked on every cycle. A stop leaves the channel not running. The mode bit stays put when written during a run. The interrupt appears only after a count-clock enable. A decrement lowers the count by exactly one, and the counter holds when no action is issued. The level holds while the timer owns it and no toggle fires, and it also holds while software owns it and writes nothing. Only the bench scenarios can show the rest: the exact reload values, where the first interrupt falls for each setting of the mode bit, a rewritten period taking effect one reload late, priority between start and stop, and the every-tick behaviour at period zero.

// File: rtl/itc_pkg.sv
// Package: shared types for the interval timer channel.
// Assumes: consumers import the package; no state lives here.
package itc_pkg;
    // Channel sequencing: stopped, armed for a fresh load, counting.
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } itc_state_e;
endpackage

// File: rtl/itc_ctrl.sv
// Module: itc_ctrl
// Sequences the channel. It handles the start and stop strobes (stop
// wins), holds the mode bit, issues the load and decrement commands to
// the counter, and generates the one-cycle interrupt pulse.
// Assumes: cnt_zero comes from the counter register of the same cycle.
module itc_ctrl
    import itc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_en,
    input  logic start_trig,
    input  logic stop_trig,
    input  logic mode_we,
    input  logic mode_din,
    input  logic cnt_zero,
    output logic do_load,
    output logic do_dec,
    output logic fire,
    output logic running,
    output logic mode_q,
    output logic irq
);
    itc_state_e state_q;
    logic       act;

    // Count-clock enables are ignored while a strobe is being applied.
    assign act     = cnt_en && (state_q != ST_STOP) && !stop_trig && !start_trig;
    assign do_load = act && ((state_q == ST_ARMED) || cnt_zero);
    assign do_dec  = act && (state_q == ST_RUN) && !cnt_zero;
    assign fire    = act && (((state_q == ST_ARMED) && mode_q) ||
                             ((state_q == ST_RUN) && cnt_zero));
    assign running = (state_q != ST_STOP);

    // Channel state: stop has priority, start re-arms, first tick starts counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_STOP;
        else if (stop_trig)
            state_q <= ST_STOP;
        else if (start_trig)
            state_q <= ST_ARMED;
        else if (act && (state_q == ST_ARMED))
            state_q <= ST_RUN;
    end

    // Mode bit: writable only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (mode_we && (state_q == ST_STOP))
            mode_q <= mode_din;
    end

    // Interrupt pulse: registered copy of the fire event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= fire;
    end

    // R7
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_trig |=> !running);

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode_we) |=> (mode_q == $past(mode_q)));

    // R4
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cnt_en));
endmodule

// File: rtl/itc_counter.sv
// Module: itc_counter
// Holds the period register and the down counter. The counter loads from
// the period or decrements, as commanded by the control logic.
// Assumes: do_load and do_dec are never both high.
module itc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_din,
    input  logic             do_load,
    input  logic             do_dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] period_q,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    assign cnt_zero = (cnt_q == '0);

    // Period register: writable at any time, used at the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period_q <= '0;
        else if (period_we)
            period_q <= period_din;
    end

    // Counter: reload or count down on command, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_RST;
        else if (do_load)
            cnt_q <= period_q;
        else if (do_dec)
            cnt_q <= cnt_q - ONE;
    end

    // R4
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_dec |=> (cnt_q == $past(cnt_q) - ONE));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_load && !do_dec) |=> $stable(cnt_q));
endmodule

// File: rtl/itc_wave.sv
// Module: itc_wave
// Owns the output-enable bit and the wave level. The timer toggles the
// level while output is enabled. Software writes it while output is
// disabled, or while the channel is stopped.
// Assumes: fire is only high while the channel runs.
module itc_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic running,
    input  logic oe_we,
    input  logic oe_din,
    input  logic lvl_we,
    input  logic lvl_din,
    output logic oe_q,
    output logic lvl_q
);
    // Output-enable bit: writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_q <= 1'b0;
        else if (oe_we)
            oe_q <= oe_din;
    end

    // Wave level: timer toggle when enabled, else software write if allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= 1'b0;
        else if (oe_q && fire)
            lvl_q <= ~lvl_q;
        else if (lvl_we && (!oe_q || !running))
            lvl_q <= lvl_din;
    end

    // R9
    timer_owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_q && running && !fire) |=> $stable(lvl_q));

    // R8
    sw_owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_q && !lvl_we) |=> $stable(lvl_q));
endmodule

// File: rtl/interval_timer_chan.sv
// Module: interval_timer_chan (top)
// One interval timer channel: control sequencing, a reloadable down
// counter and a toggling wave output.
// Assumes: cnt_en is already divided down by an external prescaler.
module interval_timer_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start_trig,
    input  logic             stop_trig,
    input  logic             period_we,
    input  logic [CNT_W-1:0] period_din,
    input  logic             mode_we,
    input  logic             mode_din,
    input  logic             oe_we,
    input  logic             oe_din,
    input  logic             lvl_we,
    input  logic             lvl_din,
    output logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] period_val,
    output logic             running,
    output logic             mode_val,
    output logic             oe_val,
    output logic             wave_out,
    output logic             irq
);
    logic do_load, do_dec, fire, cnt_zero;

    itc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .start_trig (start_trig),
        .stop_trig  (stop_trig),
        .mode_we    (mode_we),
        .mode_din   (mode_din),
        .cnt_zero   (cnt_zero),
        .do_load    (do_load),
        .do_dec     (do_dec),
        .fire       (fire),
        .running    (running),
        .mode_q     (mode_val),
        .irq        (irq)
    );

    itc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_we  (period_we),
        .period_din (period_din),
        .do_load    (do_load),
        .do_dec     (do_dec),
        .cnt_q      (count_val),
        .period_q   (period_val),
        .cnt_zero   (cnt_zero)
    );

    itc_wave u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .running (running),
        .oe_we   (oe_we),
        .oe_din  (oe_din),
        .lvl_we  (lvl_we),
        .lvl_din (lvl_din),
        .oe_q    (oe_val),
        .lvl_q   (wave_out)
    );
endmodule

// File: tb/interval_timer_chan_tb.sv
module interval_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 0, start_trig = 0, stop_trig = 0;
    logic        period_we = 0, mode_we = 0, mode_din = 0;
    logic        oe_we = 0, oe_din = 0, lvl_we = 0, lvl_din = 0;
    logic [15:0] period_din = '0;
    logic [15:0] count_val, period_val;
    logic        running, mode_val, oe_val, wave_out, irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    interval_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .start_trig(start_trig), .stop_trig(stop_trig),
        .period_we(period_we), .period_din(period_din),
        .mode_we(mode_we), .mode_din(mode_din),
        .oe_we(oe_we), .oe_din(oe_din),
        .lvl_we(lvl_we), .lvl_din(lvl_din),
        .count_val(count_val), .period_val(period_val),
        .running(running), .mode_val(mode_val), .oe_val(oe_val),
        .wave_out(wave_out), .irq(irq)
    );

    // Vector: {cnt_en, expected count, expected irq, expected wave}
    // Period 3, mode 1, output enabled, channel just started.
    localparam logic [18:0] VEC [10] = '{
        {1'b1, 16'd3, 1'b1, 1'b1},
        {1'b1, 16'd2, 1'b0, 1'b1},
        {1'b1, 16'd1, 1'b0, 1'b1},
        {1'b1, 16'd0, 1'b0, 1'b1},
        {1'b1, 16'd3, 1'b1, 1'b0},
        {1'b0, 16'd3, 1'b0, 1'b0},
        {1'b1, 16'd2, 1'b0, 1'b0},
        {1'b1, 16'd1, 1'b0, 1'b0},
        {1'b1, 16'd0, 1'b0, 1'b0},
        {1'b1, 16'd3, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle with cnt_en driven; results sampled at the following negedge.
    task automatic step(input logic en);
        cnt_en = en;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic do_start();
        start_trig = 1'b1; @(negedge clk); start_trig = 1'b0;
    endtask

    task automatic do_stop();
        stop_trig = 1'b1; @(negedge clk); stop_trig = 1'b0;
    endtask

    task automatic wr_period(input logic [15:0] v);
        period_we = 1'b1; period_din = v; @(negedge clk); period_we = 1'b0;
    endtask

    task automatic wr_mode(input logic v);
        mode_we = 1'b1; mode_din = v; @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_oe(input logic v);
        oe_we = 1'b1; oe_din = v; @(negedge clk); oe_we = 1'b0;
    endtask

    task automatic wr_lvl(input logic v);
        lvl_we = 1'b1; lvl_din = v; @(negedge clk); lvl_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count_val, 32'hFFFF);
        check("R1 period", period_val, 0);
        check("R1 wave", wave_out, 0);
        check("R1 running", running, 0);
        check("R1 irq", irq, 0);
        check("R1 mode", mode_val, 0);
        check("R1 oe", oe_val, 0);

        // R2 start with a table walk (R3 mode 1, R4 countdown)
        wr_period(16'd3);
        wr_mode(1'b1);
        wr_oe(1'b1);
        do_start();
        check("R2 running after start", running, 1);
        check("R2 count held before first tick", count_val, 32'hFFFF);
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][18]);
            check("R4 table count", count_val, {16'd0, VEC[i][17:2]});
            check("R3 R4 table irq", irq, VEC[i][1]);
            check("R3 R4 table wave", wave_out, VEC[i][0]);
        end
        @(negedge clk);
        check("R4 irq lasts one cycle", irq, 0);

        // R6 mode write while running is ignored
        wr_mode(1'b0);
        check("R6 mode frozen while running", mode_val, 1);
        // R9 level write ignored while running with output enabled
        wr_lvl(1'b0);
        check("R9 level write ignored", wave_out, 1);

        // R5 period rewrite applies at next reload
        wr_period(16'd5);
        tick_n(3);
        check("R5 old countdown finishes", count_val, 0);
        step(1'b1);
        check("R5 new period loaded", count_val, 5);
        check("R5 irq at reload", irq, 1);
        check("R5 wave toggled", wave_out, 0);

        // R7 stop freezes state
        tick_n(2);
        do_stop();
        check("R7 running cleared", running, 0);
        tick_n(4);
        check("R7 count held", count_val, 3);
        check("R7 irq quiet", irq, 0);
        check("R7 wave held", wave_out, 0);

        // R9 level write accepted when stopped
        wr_lvl(1'b1);
        check("R9 level write when stopped", wave_out, 1);

        // R6 mode write accepted when stopped; R3 mode 0; R8 oe 0
        wr_mode(1'b0);
        check("R6 mode write when stopped", mode_val, 0);
        wr_oe(1'b0);
        wr_period(16'd2);
        do_start();
        step(1'b1);
        check("R3 mode0 load count", count_val, 2);
        check("R3 mode0 no irq at start", irq, 0);
        tick_n(2);
        step(1'b1);
        check("R8 reload count", count_val, 2);
        check("R8 irq still fires", irq, 1);
        check("R8 no toggle with oe 0", wave_out, 1);
        wr_lvl(1'b0);
        check("R8 level follows write while running", wave_out, 0);

        // R10 restart while running
        step(1'b1);
        check("R10 count before restart", count_val, 1);
        do_start();
        check("R10 still running", running, 1);
        step(1'b1);
        check("R10 fresh load", count_val, 2);
        check("R10 no irq in mode 0", irq, 0);

        // R10 start and stop together: stop wins
        start_trig = 1'b1; stop_trig = 1'b1;
        @(negedge clk);
        start_trig = 1'b0; stop_trig = 1'b0;
        check("R10 stop wins", running, 0);

        // R11 period zero: irq and toggle every tick
        wr_period(16'd0);
        wr_mode(1'b1);
        wr_oe(1'b1);
        do_start();
        step(1'b1);
        check("R11 count", count_val, 0);
        check("R11 irq 1", irq, 1);
        check("R11 wave 1", wave_out, 1);
        step(1'b1);
        check("R11 irq 2", irq, 1);
        check("R11 wave 2", wave_out, 0);
        step(1'b1);
        check("R11 irq 3", irq, 1);
        check("R11 wave 3", wave_out, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule